// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is an SMBus target that lets a host read and write a small bank of 8-bit configuration registers. It samples SCL and SDA on the system clock and finds start, repeated-start and stop conditions in the sampled values. It acknowledges its own 7-bit address and moves data most significant bit first. It drives the bus only by pulling SDA low, through an open-drain request output. Every register is also presented at all times on a flat parallel output, so clock-control logic can use the fields directly.

The first byte after the address is a command byte, and it selects one of two access styles. With bit 7 set, the transfer is indexed: bits 6:0 give the register offset, and one byte or a two-byte word (low byte first) is read or written there. With bit 7 clear, the transfer is a block transfer. It always starts at register 0. A write carries a byte count ahead of its data. A read, issued after a repeated start, returns the register count and then registers 0, 1, 2 and so on, until the host NAKs a byte. One register holds a fixed identification value. Two bits of another register capture strap inputs at reset. Host writes cannot change either of these.

Top module: `smbCfgTarget`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal DEV_ADDR (default 0x69). After any other address it leaves SDA released for the rest of the transfer and changes no register, until the next start.
- R2: Command bit 7 = 1 selects indexed access at the offset in bits 6:0. Command bit 7 = 0 selects block access beginning at register 0, whatever the value of bits 6:0.
- R3: A block write takes a byte count and then data bytes. These are stored in registers 0, 1, 2 and onward. Data bytes past the count, and bytes past the last register, are acknowledged but discarded.
- R4: A block read (write command, repeated start, read address) first returns NUM_REGS (16 by default) as the byte count. It then returns register 0, register 1 and onward, until the host NAKs.
- R5: An indexed write stores the first data byte at the offset and the second at offset+1. Any further data byte is acknowledged and ignored.
- R6: An indexed read after a repeated start returns the register at the offset and then the following registers, until the host NAKs.
- R7: Every byte in either direction is transferred with bit 7 first and bit 0 last.
- R8: Reset values are: register 1 = {strapIn, 6'b000010}; register 2 = 0xFF; register 3 = 0xF3; register 4 = 0xFF; register 5 = 0x1F; register 6 = 0x01; register 7 = 0x6C; register 8 = 0x3E; register 15 = 0x03. Every other register resets to 0x00.
- R9: Register 6 and bits 7:6 of register 1 keep their reset values when written. The writable bits of register 1 still take the written data.
- R10: An offset of NUM_REGS or higher reads as 0x00, and writes to it are ignored.
- R11: A stop or start condition in the middle of a byte ends the transfer, and the register that byte was aimed at is not changed.
- R12: ctrlOut[8*i+7:8*i] always equals register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Synchronous active-low reset; strapIn is captured while it is low |
| sclIn | input | 1 | SMBus clock line as seen at the pin |
| sdaIn | input | 1 | SMBus data line as seen at the pin (wired-AND value) |
| strapIn | input | 2 | Strap levels stored in register 1 bits 7:6 at reset |
| sdaOutLow | output | 1 | 1 = pull SDA low; 0 = release SDA |
| ctrlOut | output | NUM_REGS*8 | All registers concatenated, register i at bits 8*i+7:8*i |

## Verification
On every cycle, the embedded assertions check four things: a stored byte is always accompanied by an acknowledge, SDA is released while the engine is idle, a transmitted bit changes only after an SCL falling edge, and the read-only fields and out-of-range writes leave the register image unchanged. Several behaviours can only be shown by the bench's scenarios, because they depend on a whole transfer and not on one cycle:
- a mismatched address leaves the bank untouched,
- block transfers ignore the low command bits,
- the count and data ordering on block reads,
- word low/high ordering,
- discarding of bytes past the count,
- abandoning a half-received byte.

The bench keeps a behavioural register model and compares the full parallel output against it on every idle clock.

// File: rtl/smbCfg_pkg.sv
package smbCfg_pkg;

  typedef enum logic [2:0] {
    L_IDLE,
    L_RX,
    L_RXACK,
    L_TX,
    L_TXACK
  } linkStateT;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_COUNT,
    K_DATA
  } rxKindT;

  // strobes from the protocol engine to the register bank
  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrAddr;
    logic [7:0] wrData;
    logic [7:0] rdAddr;
  } bankReqT;

  function automatic logic [7:0] regDefault(input int idx, input logic [1:0] strap);
    case (idx)
      1:       regDefault = {strap, 6'b000010};
      2:       regDefault = 8'hFF;
      3:       regDefault = 8'hF3;
      4:       regDefault = 8'hFF;
      5:       regDefault = 8'h1F;
      6:       regDefault = 8'h01;
      7:       regDefault = 8'h6C;
      8:       regDefault = 8'h3E;
      15:      regDefault = 8'h03;
      default: regDefault = 8'h00;
    endcase
  endfunction

  // bits set here keep their value on a host write
  function automatic logic [7:0] roMask(input int idx);
    case (idx)
      1:       roMask = 8'hC0;
      6:       roMask = 8'hFF;
      default: roMask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbLink.sv
module smbLink
  import smbCfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output bankReqT    req,
  output logic       sdaOutLow
);

  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);
  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] LAST_BIT  = 4'd7;

  // input sampling
  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaS;

  // engine state
  linkStateT  state;
  rxKindT     kind;
  logic [3:0] bitCnt;
  logic [7:0] shIn, shOut, ptr, wrLeft;
  logic       isBlock, countFirst, afterTx, nakSeen;
  logic       wrPulse;
  logic [7:0] wrAddrQ, wrDataQ;
  logic [7:0] nextByte;
  logic [7:0] ptrInc;

  assign nextByte = countFirst ? COUNT_VAL : rdData;
  assign ptrInc   = (ptr == 8'hFF) ? ptr : ptr + 8'd1;

  always_comb begin
    req.wrEn   = wrPulse;
    req.wrAddr = wrAddrQ;
    req.wrData = wrDataQ;
    req.rdAddr = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= L_IDLE;
      kind       <= K_ADDR;
      bitCnt     <= '0;
      shIn       <= '0;
      shOut      <= '0;
      ptr        <= '0;
      wrLeft     <= '0;
      isBlock    <= 1'b0;
      countFirst <= 1'b0;
      afterTx    <= 1'b0;
      nakSeen    <= 1'b0;
      wrPulse    <= 1'b0;
      wrAddrQ    <= '0;
      wrDataQ    <= '0;
      sdaOutLow  <= 1'b0;
    end else begin
      wrPulse <= 1'b0;
      if (stopSeen) begin
        state     <= L_IDLE;
        sdaOutLow <= 1'b0;
      end else if (startSeen) begin
        state     <= L_RX;
        kind      <= K_ADDR;
        bitCnt    <= '0;
        sdaOutLow <= 1'b0;
      end else begin
        case (state)
          L_RX: begin
            if (sclRise && bitCnt < BYTE_BITS) begin
              shIn   <= {shIn[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == BYTE_BITS) begin
              bitCnt  <= '0;
              afterTx <= 1'b0;
              case (kind)
                K_ADDR: begin
                  if (shIn[7:1] == DEV_ADDR) begin
                    sdaOutLow <= 1'b1;
                    state     <= L_RXACK;
                    if (shIn[0]) begin
                      afterTx    <= 1'b1;
                      countFirst <= isBlock;
                    end else begin
                      kind <= K_CMD;
                    end
                  end else begin
                    state <= L_IDLE;
                  end
                end
                K_CMD: begin
                  isBlock   <= ~shIn[7];
                  ptr       <= shIn[7] ? {1'b0, shIn[6:0]} : 8'd0;
                  kind      <= shIn[7] ? K_DATA : K_COUNT;
                  wrLeft    <= shIn[7] ? 8'd2 : 8'd0;
                  sdaOutLow <= 1'b1;
                  state     <= L_RXACK;
                end
                K_COUNT: begin
                  wrLeft    <= shIn;
                  kind      <= K_DATA;
                  sdaOutLow <= 1'b1;
                  state     <= L_RXACK;
                end
                default: begin
                  if (wrLeft != 8'd0) begin
                    wrPulse <= 1'b1;
                    wrAddrQ <= ptr;
                    wrDataQ <= shIn;
                    wrLeft  <= wrLeft - 8'd1;
                    ptr     <= ptrInc;
                  end
                  sdaOutLow <= 1'b1;
                  state     <= L_RXACK;
                end
              endcase
            end
          end
          L_RXACK: begin
            if (sclFall) begin
              if (afterTx) begin
                shOut      <= nextByte;
                sdaOutLow  <= ~nextByte[7];
                countFirst <= 1'b0;
                if (!countFirst) ptr <= ptrInc;
                state <= L_TX;
              end else begin
                sdaOutLow <= 1'b0;
                state     <= L_RX;
              end
            end
          end
          L_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaOutLow <= 1'b0;
                bitCnt    <= '0;
                state     <= L_TXACK;
              end else begin
                shOut     <= {shOut[6:0], 1'b0};
                sdaOutLow <= ~shOut[6];
                bitCnt    <= bitCnt + 4'd1;
              end
            end
          end
          L_TXACK: begin
            if (sclRise) begin
              nakSeen <= sdaS;
            end else if (sclFall) begin
              if (nakSeen) begin
                state <= L_IDLE;
              end else begin
                shOut      <= nextByte;
                sdaOutLow  <= ~nextByte[7];
                countFirst <= 1'b0;
                if (!countFirst) ptr <= ptrInc;
                state <= L_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  wr_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> sdaOutLow);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == L_IDLE) |-> !sdaOutLow);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == L_TX && $past(state) == L_TX && !$past(sclFall)) |-> $stable(sdaOutLow));

  // R11
  rx_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == L_RX) |-> (bitCnt <= BYTE_BITS));

endmodule

// File: rtl/smbRegBank.sv
module smbRegBank
  import smbCfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            strapIn,
  input  bankReqT               req,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam int ID_IDX    = 6;
  localparam int STRAP_IDX = 1;

  logic [7:0] regVal [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        regVal[i] <= regDefault(i, strapIn);
      end else if (req.wrEn && req.wrAddr == 8'(i)) begin
        regVal[i] <= (regVal[i] & roMask(i)) | (req.wrData & ~roMask(i));
      end
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (req.rdAddr == 8'(i)) rdData = regVal[i];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign regFlat[g*8 +: 8] = regVal[g];
  end

  if (NUM_REGS > ID_IDX) begin : gIdChk
    // R9
    ro_id_chk: assert property (@(posedge clk) disable iff (!rstN)
      $stable(regVal[ID_IDX]));
  end

  if (NUM_REGS > STRAP_IDX) begin : gStrapChk
    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      $stable(regVal[STRAP_IDX][7:6]));
  end

  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req.wrEn && req.wrAddr >= 8'(NUM_REGS)) |=> $stable(regFlat));

endmodule

// File: rtl/smbCfgTarget.sv
module smbCfgTarget
  import smbCfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [1:0]            strapIn,
  output logic                  sdaOutLow,
  output logic [NUM_REGS*8-1:0] ctrlOut
);

  bankReqT    bankReq;
  logic [7:0] bankRdData;

  smbLink #(
    .DEV_ADDR(DEV_ADDR),
    .NUM_REGS(NUM_REGS)
  ) u_link (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rdData   (bankRdData),
    .req      (bankReq),
    .sdaOutLow(sdaOutLow)
  );

  smbRegBank #(
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .strapIn(strapIn),
    .req    (bankReq),
    .rdData (bankRdData),
    .regFlat(ctrlOut)
  );

endmodule

// File: tb/smbCfgTarget_tb.sv
`timescale 1ns/1ps
module smbCfgTarget_tb;

  localparam logic [6:0] ADDR = 7'h69;
  localparam int         NREG = 16;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaOutLow;
  logic [NREG*8-1:0] ctrlOut;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOutLow;

  always #4 clk = ~clk;

  smbCfgTarget #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapIn(strap), .sdaOutLow(sdaOutLow), .ctrlOut(ctrlOut)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmpEn = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] rdBuf [32];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] modelFlat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // R12: per-clock comparison of the parallel output against the model
  always @(negedge clk) begin
    if (cmpEn && !done) begin
      total++;
      if (ctrlOut !== modelFlat()) begin
        bad++;
        $display("FAIL R12 act=%0h exp=%0h", ctrlOut, modelFlat());
      end
    end
  end

  function automatic void modelWrite(input int idx, input logic [7:0] v);
    if (idx >= NREG || idx == 6) return;
    if (idx == 1) model[1] = {model[1][7:6], v[5:0]};
    else model[idx] = v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    acked = !sdaLine;
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      sclM = 1'b1; tick(Q);
      b = {b[6:0], sdaLine};
      tick(Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = ackIt ? 1'b0 : 1'b1; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [7:0] q[$], input string tag);
    bit a;
    cmpEn = 1'b0;
    startC();
    sendByte({ADDR, 1'b0}, a); check(a, {tag, " R1 addr ack"}, a, 1);
    sendByte(cmd, a);          check(a, {tag, " cmd ack"}, a, 1);
    foreach (q[i]) begin
      sendByte(q[i], a);       check(a, {tag, " R3 data ack"}, a, 1);
    end
    stopC();
    tick(4);
    cmpEn = 1'b1;
  endtask

  task automatic doRead(input logic [7:0] cmd, input int n, input string tag);
    bit a;
    logic [7:0] b;
    cmpEn = 1'b0;
    startC();
    sendByte({ADDR, 1'b0}, a); check(a, {tag, " R1 addr ack"}, a, 1);
    sendByte(cmd, a);          check(a, {tag, " cmd ack"}, a, 1);
    startC();
    sendByte({ADDR, 1'b1}, a); check(a, {tag, " R1 read addr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n-1, b);
      rdBuf[i] = b;
    end
    stopC();
    tick(4);
    cmpEn = 1'b1;
  endtask

  initial begin
    logic [7:0] q[$];
    bit a;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[1] = {strap, 6'b000010};
    model[2] = 8'hFF; model[3] = 8'hF3; model[4] = 8'hFF; model[5] = 8'h1F;
    model[6] = 8'h01; model[7] = 8'h6C; model[8] = 8'h3E; model[15] = 8'h03;

    tick(6);
    rstN = 1'b1;
    tick(4);
    // R8 reset state
    check(ctrlOut === modelFlat(), "R8 reset defaults", 0, 0);
    check(ctrlOut[8*1 +: 8] == 8'h82, "R8 strap latch", ctrlOut[8*1 +: 8], 8'h82);
    cmpEn = 1'b1;

    // R9 / R6: byte read of the fixed ID register
    doRead(8'h86, 1, "id");
    check(rdBuf[0] == 8'h01, "R9 id read", rdBuf[0], 8'h01);

    // R1: foreign address gets no ACK and no write
    cmpEn = 1'b0;
    startC();
    sendByte({7'h2A, 1'b0}, a); check(!a, "R1 foreign no ack", a, 0);
    sendByte(8'h82, a);         check(!a, "R1 later byte no ack", a, 0);
    sendByte(8'h00, a);         check(!a, "R1 data no ack", a, 0);
    stopC(); tick(4);
    cmpEn = 1'b1;
    check(ctrlOut[8*2 +: 8] == 8'hFF, "R1 reg2 untouched", ctrlOut[8*2 +: 8], 8'hFF);

    // R5 / R2: indexed byte write
    q = '{8'hA5};
    modelWrite(3, 8'hA5);
    doWrite(8'h83, q, "byteWr");
    check(ctrlOut[8*3 +: 8] == 8'hA5, "R5 byte write", ctrlOut[8*3 +: 8], 8'hA5);

    // R7: single set bit lands in bit 0
    q = '{8'h01};
    modelWrite(0, 8'h01);
    doWrite(8'h80, q, "msb");
    check(ctrlOut[7:0] == 8'h01, "R7 bit order", ctrlOut[7:0], 8'h01);

    // R5: word write, third byte ignored
    q = '{8'h12, 8'h34, 8'h56};
    modelWrite(8, 8'h12); modelWrite(9, 8'h34);
    doWrite(8'h88, q, "wordWr");
    check(ctrlOut[8*10 +: 8] == 8'h00, "R5 third byte ignored", ctrlOut[8*10 +: 8], 8'h00);

    // R6: word read
    doRead(8'h88, 2, "wordRd");
    check(rdBuf[0] == 8'h12, "R6 word low", rdBuf[0], 8'h12);
    check(rdBuf[1] == 8'h34, "R6 word high", rdBuf[1], 8'h34);

    // R2 / R3 / R9: block write with non-zero low command bits, count 3 plus extra
    q = '{8'h03, 8'h11, 8'h22, 8'h33, 8'h44};
    modelWrite(0, 8'h11); modelWrite(1, 8'h22); modelWrite(2, 8'h33);
    doWrite(8'h05, q, "blkWr");
    check(ctrlOut[8*1 +: 8] == 8'hA2, "R9 strap kept", ctrlOut[8*1 +: 8], 8'hA2);
    check(ctrlOut[8*3 +: 8] == 8'hA5, "R3 past count ignored", ctrlOut[8*3 +: 8], 8'hA5);
    check(ctrlOut[7:0] == 8'h11, "R2 block starts at 0", ctrlOut[7:0], 8'h11);

    // R3 / R10: block write longer than the bank
    q = '{8'd20};
    for (int i = 0; i < 20; i++) begin
      q.push_back(8'(i*7+1));
      modelWrite(i, 8'(i*7+1));
    end
    doWrite(8'h00, q, "blkLong");
    check(ctrlOut[8*6 +: 8] == 8'h01, "R9 id after block", ctrlOut[8*6 +: 8], 8'h01);

    // R4: block read, count then data
    doRead(8'h00, NREG+1, "blkRd");
    check(rdBuf[0] == 8'(NREG), "R4 byte count", rdBuf[0], NREG);
    for (int i = 0; i < NREG; i++)
      check(rdBuf[i+1] == model[i], "R4 block data", rdBuf[i+1], model[i]);

    // R10: out-of-range offset
    q = '{8'h77};
    doWrite(8'hD0, q, "oor");
    doRead(8'hD0, 1, "oorRd");
    check(rdBuf[0] == 8'h00, "R10 oor reads zero", rdBuf[0], 8'h00);

    // R11: stop in mid-byte
    cmpEn = 1'b0;
    startC();
    sendByte({ADDR, 1'b0}, a); check(a, "R11 addr ack", a, 1);
    sendByte(8'h82, a);        check(a, "R11 cmd ack", a, 1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    stopC(); tick(4);
    cmpEn = 1'b1;
    check(ctrlOut[8*2 +: 8] == model[2], "R11 abort keeps reg", ctrlOut[8*2 +: 8], model[2]);
    doRead(8'h82, 1, "afterAbort");
    check(rdBuf[0] == model[2], "R11 readback", rdBuf[0], model[2]);

    tick(10);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule